// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block gathers up to 32 level-type interrupt sources and signals the processor by posting a one-word memory write. Each source passes through a synchronizer and an edge detector. A rising edge sets the source's bit in a pending register. If the source is enabled in the mask register, its bit is also set in a request register. When at least one enabled source rises and the bus-error bit of the control register is clear, the block queues a message write. The message address is the programmable interrupt-address register with its five low bits cleared. The message data is those five low bits. The processor can use the data value to tell interrupt vectors apart.

Software reaches the block over a simple word-addressed register bus. The bus takes one access per cycle, and read data appears one cycle after the read strobe. Next to the interrupt registers sits a small system group: a power-control register that raises a power-off request, an error-log register that also records dropped messages, a version register, an I/O-reset register and an arbitration-mask register. Messages wait in a small FIFO that drives a valid/ready write port toward the memory system.

Top module: `msgirq_ctrl`

## Requirements
- R1: After reset the interrupt-address register reads the parameter value 0xFFFE0003. Every other register reads zero, msg_valid_o is low, and power_off_o and bad_mask_o are low.
- R2: A read strobe returns data on reg_rdata_o in the next cycle, and the value holds until the next read. Byte offsets are: request 0x00, mask 0x04, pending 0x08, control 0x0C, interrupt address 0x10, power control 0x100, error log 0x104, version 0x108, I/O reset 0x10C, arbitration mask 0x110. Any other offset reads zero.
- R3: Each source is synchronized through two flops. A rising edge sets the source's pending bit, and also its request bit when the source's mask bit is set. Writes to the request register have no effect. Request bits clear only by reset.
- R4: A read of the pending register returns its value and then clears it. A write to it clears it whatever the data. A source edge in the same cycle as the clear leaves that source's bit set.
- R5: In a cycle where at least one source edge meets a set mask bit and control bit 8 is clear, one message is queued; several such edges in one cycle give a single message. The message address is the interrupt-address register with bits 4:0 forced to zero, and the data is bits 4:0 of that register, zero-extended. Bits 31:24 of msg_data_o carry the most significant byte. A level held high produces no further messages.
- R6: The control register reads back only bit 8; all other bits read zero. While bit 8 is set, no messages are queued, but the pending and request registers still update.
- R7: Messages leave in arrival order through a 4-entry FIFO. While msg_valid_o is high and msg_ready_i is low, the address and data hold steady.
- R8: A message that arrives while the FIFO holds 4 entries is dropped, and bit 31 of the error log is set. That bit stays set until software overwrites the error log.
- R9: A mask write stores its data in full. It pulses bad_mask_o for one cycle when the data has a bit outside {5, 7, 8, 9, 13, 14, 16..21, 26} and is not all ones.
- R10: A write of 0x02 to power control pulses power_off_o for one cycle; other values do nothing. Power control, version and I/O reset always read zero.
- R11: The error-log and arbitration-mask registers store and read back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source levels, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the strobe |
| msg_valid_o | output | 1 | Message write request |
| msg_ready_i | input | 1 | Memory side accepts the message |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |
| power_off_o | output | 1 | One-cycle power-off request |
| bad_mask_o | output | 1 | One-cycle flag for an illegal mask write |

## Verification
The hardest case to reach is the FIFO overflow. It requires more qualifying source edges than the FIFO can hold while the memory side stalls. The stimulus holds msg_ready_i low and toggles one enabled source six times, with gaps long enough for the synchronizer to see every edge. It then reads the error log and releases the port to drain the four surviving messages. A second case that is hard to time is a pending-register read that lands in the same cycle as a new edge. To cover it, the bench issues reads every cycle while a source toggles. A behavioural model predicts each outcome cycle by cycle.

// File: rtl/irqc_pkg.sv
// Package: irqc_pkg
// Holds the register byte offsets and fixed field positions shared by the
// interrupt controller, its sub-blocks and its checker.
package irqc_pkg;
    localparam int unsigned OFF_REQ   = 'h000;
    localparam int unsigned OFF_MASK  = 'h004;
    localparam int unsigned OFF_PEND  = 'h008;
    localparam int unsigned OFF_CTRL  = 'h00C;
    localparam int unsigned OFF_ADDR  = 'h010;
    localparam int unsigned OFF_PWR   = 'h100;
    localparam int unsigned OFF_ERR   = 'h104;
    localparam int unsigned OFF_VER   = 'h108;
    localparam int unsigned OFF_IORST = 'h10C;
    localparam int unsigned OFF_ARB   = 'h110;

    localparam int unsigned BUSERR_BIT   = 8;   // control bit that blocks messages
    localparam int unsigned PWR_OFF_CODE = 2;   // power-control value that requests off
    localparam int unsigned MSG_ALIGN    = 5;   // low address bits reused as payload
endpackage

// File: rtl/irqc_src_edge.sv
// Module: irqc_src_edge
// Synchronizes N asynchronous level inputs through STAGES flops and flags a
// one-cycle rise for each input that goes from low to high.
// Assumes: STAGES >= 2; inputs are levels held for longer than one clock.
module irqc_src_edge #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] sync_q [STAGES];
    logic [N-1:0] prev_q;

    // First synchronizer stage captures the raw levels.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= '0;
        else        sync_q[0] <= lvl_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Further stages shift the level along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    // Previous synchronized level, kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irqc_msg_fifo.sv
// Module: irqc_msg_fifo
// Small first-in first-out queue of message words with a valid/ready output.
// Assumes: DEPTH is a power of two and at least 2; a push while full is
// discarded by the caller (full is reported before any same-cycle pop).
module irqc_msg_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    output logic         full_o,
    output logic         valid_o,
    input  logic         ready_i,
    output logic [W-1:0] data_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          do_push, do_pop;

    assign full_o  = (count_q == CW'(DEPTH));
    assign valid_o = (count_q != '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = valid_o && ready_i;
    assign data_o  = mem_q[rd_ptr_q];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= push_data_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end
endmodule

// File: rtl/irqc_sys_regs.sv
// Module: irqc_sys_regs
// System-control register group: power control, error log (with a sticky
// overflow bit), version, I/O reset and arbitration mask.
// Assumes: read data is combinational here and registered by the parent;
// offsets outside this group read as zero.
module irqc_sys_regs
    import irqc_pkg::*;
#(
    parameter int AW      = 12,
    parameter int DW      = 32,
    parameter int OVF_BIT = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          ovf_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] errlog_o,
    output logic          power_off_o
);
    localparam logic [AW-1:0] A_PWR = AW'(OFF_PWR);
    localparam logic [AW-1:0] A_ERR = AW'(OFF_ERR);
    localparam logic [AW-1:0] A_ARB = AW'(OFF_ARB);

    logic [DW-1:0] err_q, arb_q;
    logic          poff_q;
    logic [DW-1:0] err_d;

    // Next error-log value: software write first, then overflow sets its bit.
    always_comb begin
        err_d = err_q;
        if (wr_i && addr_i == A_ERR) err_d = wdata_i;
        if (ovf_i) err_d[OVF_BIT] = 1'b1;
    end

    // Register updates and the one-cycle power-off pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            arb_q  <= '0;
            poff_q <= 1'b0;
        end else begin
            err_q  <= err_d;
            if (wr_i && addr_i == A_ARB) arb_q <= wdata_i;
            poff_q <= wr_i && addr_i == A_PWR && wdata_i == DW'(PWR_OFF_CODE);
        end
    end

    // Read mux; power, version and I/O reset read as zero.
    always_comb begin
        if (addr_i == A_ERR)      rdata_o = err_q;
        else if (addr_i == A_ARB) rdata_o = arb_q;
        else                      rdata_o = '0;
    end

    assign errlog_o    = err_q;
    assign power_off_o = poff_q;
endmodule

// File: rtl/msgirq_ctrl.sv
// Module: msgirq_ctrl
// Interrupt controller that delivers interrupts as posted memory writes.
// Holds request, mask, pending, control and address registers, queues one
// message per cycle with a qualifying source edge, and hosts the system group.
// Assumes: NSRC <= DW; one register access per cycle; read data one cycle later.
module msgirq_ctrl
    import irqc_pkg::*;
#(
    parameter int              AW          = 12,
    parameter int              DW          = 32,
    parameter int              NSRC        = 32,
    parameter int              FIFO_DEPTH  = 4,
    parameter int              SYNC_STAGES = 2,
    parameter int              OVF_BIT     = 31,
    parameter logic [DW-1:0]   IAR_RESET   = 32'hFFFE_0003,
    parameter logic [NSRC-1:0] LEGAL_MASK  = 32'h043F_63A0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            reg_wr_i,
    input  logic            reg_rd_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    output logic            msg_valid_o,
    input  logic            msg_ready_i,
    output logic [DW-1:0]   msg_addr_o,
    output logic [DW-1:0]   msg_data_o,
    output logic            power_off_o,
    output logic            bad_mask_o
);
    localparam int            MSG_W      = 2 * DW;
    localparam logic [DW-1:0] LOW_BITS   = DW'((1 << MSG_ALIGN) - 1);
    localparam logic [AW-1:0] A_REQ      = AW'(OFF_REQ);
    localparam logic [AW-1:0] A_MASK     = AW'(OFF_MASK);
    localparam logic [AW-1:0] A_PEND     = AW'(OFF_PEND);
    localparam logic [AW-1:0] A_CTRL     = AW'(OFF_CTRL);
    localparam logic [AW-1:0] A_ADDR     = AW'(OFF_ADDR);

    logic [NSRC-1:0]  rise, req_q, mask_q, pend_q;
    logic             buserr_q, bad_q;
    logic [DW-1:0]    iar_q, core_rdata, sys_rdata, rdata_q, errlog_w;
    logic             qualify, fifo_full, ovf, pend_clr, mask_illegal;
    logic [MSG_W-1:0] push_word, head_word;

    irqc_src_edge #(.N(NSRC), .STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(src_i), .rise_o(rise)
    );

    assign qualify   = (|(rise & mask_q)) && !buserr_q;
    assign ovf       = qualify && fifo_full;
    assign push_word = {iar_q & ~LOW_BITS, iar_q & LOW_BITS};
    assign pend_clr  = (reg_rd_i || reg_wr_i) && reg_addr_i == A_PEND;
    assign mask_illegal = (|(reg_wdata_i[NSRC-1:0] & ~LEGAL_MASK))
                          && !(&reg_wdata_i[NSRC-1:0]);

    irqc_msg_fifo #(.DEPTH(FIFO_DEPTH), .W(MSG_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(qualify), .push_data_i(push_word), .full_o(fifo_full),
        .valid_o(msg_valid_o), .ready_i(msg_ready_i), .data_o(head_word)
    );

    assign msg_addr_o = head_word[MSG_W-1:DW];
    assign msg_data_o = head_word[DW-1:0];

    irqc_sys_regs #(.AW(AW), .DW(DW), .OVF_BIT(OVF_BIT)) u_sys (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .ovf_i(ovf), .rdata_o(sys_rdata),
        .errlog_o(errlog_w), .power_off_o(power_off_o)
    );

    // Interrupt register state: request, pending, mask, control, address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q    <= '0;
            pend_q   <= '0;
            mask_q   <= '0;
            buserr_q <= 1'b0;
            iar_q    <= IAR_RESET;
            bad_q    <= 1'b0;
        end else begin
            req_q  <= req_q | (rise & mask_q);
            pend_q <= (pend_clr ? '0 : pend_q) | rise;
            bad_q  <= reg_wr_i && reg_addr_i == A_MASK && mask_illegal;
            if (reg_wr_i && reg_addr_i == A_MASK) mask_q   <= reg_wdata_i[NSRC-1:0];
            if (reg_wr_i && reg_addr_i == A_CTRL) buserr_q <= reg_wdata_i[BUSERR_BIT];
            if (reg_wr_i && reg_addr_i == A_ADDR) iar_q    <= reg_wdata_i;
        end
    end

    // Read mux for the interrupt register group.
    always_comb begin
        core_rdata = '0;
        case (reg_addr_i)
            A_REQ:   core_rdata = DW'(req_q);
            A_MASK:  core_rdata = DW'(mask_q);
            A_PEND:  core_rdata = DW'(pend_q);
            A_CTRL:  core_rdata[BUSERR_BIT] = buserr_q;
            A_ADDR:  core_rdata = iar_q;
            default: core_rdata = '0;
        endcase
    end

    // Registered read data, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (reg_rd_i) rdata_q <= core_rdata | sys_rdata;
    end

    assign reg_rdata_o = rdata_q;
    assign bad_mask_o  = bad_q;
endmodule

// File: rtl/msgirq_ctrl_chk.sv
// Module: msgirq_ctrl_chk
// Property checker for msgirq_ctrl, attached with the bind below.
// Assumes: the top's internal error-log copy is named errlog_w.
module msgirq_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int AW      = 12,
    parameter int DW      = 32,
    parameter int OVF_BIT = 31
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr_i,
    input logic [AW-1:0] reg_addr_i,
    input logic [DW-1:0] reg_wdata_i,
    input logic          msg_valid_o,
    input logic          msg_ready_i,
    input logic [DW-1:0] msg_addr_o,
    input logic [DW-1:0] msg_data_o,
    input logic          power_off_o,
    input logic          bad_mask_o,
    input logic [DW-1:0] errlog_w
);
    localparam logic [AW-1:0] A_PWR  = AW'(OFF_PWR);
    localparam logic [AW-1:0] A_MASK = AW'(OFF_MASK);
    localparam logic [AW-1:0] A_ERR  = AW'(OFF_ERR);

    p_msg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));

    p_msg_format_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> msg_addr_o[MSG_ALIGN-1:0] == '0 && msg_data_o[DW-1:MSG_ALIGN] == '0);

    p_poweroff_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        power_off_o |-> $past(reg_wr_i && reg_addr_i == A_PWR && reg_wdata_i == DW'(PWR_OFF_CODE)));

    p_badmask_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mask_o |-> $past(reg_wr_i && reg_addr_i == A_MASK));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        errlog_w[OVF_BIT] && !(reg_wr_i && reg_addr_i == A_ERR) |=> errlog_w[OVF_BIT]);
endmodule

bind msgirq_ctrl msgirq_ctrl_chk #(.AW(AW), .DW(DW), .OVF_BIT(OVF_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
    .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o), .power_off_o(power_off_o),
    .bad_mask_o(bad_mask_o), .errlog_w(errlog_w)
);

// File: tb/sim_msgirq_ctrl.sv
// Bench for msgirq_ctrl: a behavioural reference model updated on every
// rising edge and compared a quarter period later, plus directed reads.
module sim_msgirq_ctrl;
    localparam int          CLK_P = 10;
    localparam int          DEPTH = 4;
    localparam logic [31:0] LEGAL = 32'h043F_63A0;
    localparam logic [31:0] IAR_RST = 32'hFFFE_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, msg_ready = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, msg_addr, msg_data;
    logic        msg_valid, power_off, bad_mask;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    msgirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_addr_o(msg_addr),
        .msg_data_o(msg_data), .power_off_o(power_off), .bad_mask_o(bad_mask)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_s1, m_s2, m_s3, m_irr, m_imr, m_ipr, m_iar, m_err, m_amr, m_rdata;
    logic        m_busoff, m_poff, m_bad;
    logic [63:0] mq[$];

    function automatic logic [31:0] mread(input logic [11:0] a);
        case (a)
            12'h000: return m_irr;
            12'h004: return m_imr;
            12'h008: return m_ipr;
            12'h00C: return m_busoff ? 32'h100 : 32'h0;
            12'h010: return m_iar;
            12'h104: return m_err;
            12'h110: return m_amr;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_irr = 0; m_imr = 0; m_ipr = 0;
            m_iar = IAR_RST; m_err = 0; m_amr = 0; m_rdata = 0;
            m_busoff = 0; m_poff = 0; m_bad = 0;
            mq.delete();
        end else begin
            logic [31:0] rise;
            bit full, qual;
            rise = m_s2 & ~m_s3;
            if (reg_rd) m_rdata = mread(reg_addr);
            full = (mq.size() == DEPTH);
            qual = ((rise & m_imr) != 0) && !m_busoff;
            if (mq.size() > 0 && msg_ready) void'(mq.pop_front());
            if (qual && !full) mq.push_back({m_iar & ~32'h1F, m_iar & 32'h1F});
            m_irr = m_irr | (rise & m_imr);
            if ((reg_rd || reg_wr) && reg_addr == 12'h008) m_ipr = 0;
            m_ipr = m_ipr | rise;
            m_poff = reg_wr && reg_addr == 12'h100 && reg_wdata == 32'h2;
            m_bad  = reg_wr && reg_addr == 12'h004 &&
                     ((reg_wdata & ~LEGAL) != 0) && (reg_wdata != 32'hFFFF_FFFF);
            if (reg_wr) begin
                case (reg_addr)
                    12'h004: m_imr = reg_wdata;
                    12'h00C: m_busoff = reg_wdata[8];
                    12'h010: m_iar = reg_wdata;
                    12'h104: m_err = reg_wdata;
                    12'h110: m_amr = reg_wdata;
                    default: ;
                endcase
            end
            if (qual && full) m_err[31] = 1'b1;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = src;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Cycle compare a quarter period after each edge.
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n) begin
            chk(reg_rdata == m_rdata, "R2 read data", reg_rdata, m_rdata);
            chk(msg_valid == (mq.size() > 0), "R7 msg_valid", msg_valid, mq.size() > 0);
            if (mq.size() > 0 && msg_valid)
                chk({msg_addr, msg_data} == mq[0], "R5 message word", {msg_addr, msg_data}, mq[0]);
            chk(power_off == m_poff, "R10 power_off", power_off, m_poff);
            chk(bad_mask == m_bad, "R9 bad_mask", bad_mask, m_bad);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic pulse_src(input int b);
        @(negedge clk); src[b] = 1'b1;
        idle(4);
        src[b] = 1'b0;
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset values
        chk(msg_valid == 0, "R1 msg_valid after reset", msg_valid, 0);
        rd_exp(12'h010, IAR_RST, "R1 address reg reset");
        rd_exp(12'h000, 0, "R1 request reset");
        rd_exp(12'h008, 0, "R1 pending reset");
        rd_exp(12'h104, 0, "R1 error log reset");

        wr(12'h004, LEGAL);
        wr(12'h010, 32'h1234_5667);
        // R5 single message, held level gives no repeat
        @(negedge clk); src[5] = 1'b1;
        idle(6);
        chk(msg_valid && msg_addr == 32'h1234_5660 && msg_data == 32'h7,
            "R5 message contents", {msg_addr, msg_data}, {32'h1234_5660, 32'h7});
        rd_exp(12'h000, 32'h20, "R3 request bit set");
        rd_exp(12'h008, 32'h20, "R4 pending read value");
        rd_exp(12'h008, 32'h0, "R4 pending cleared by read");
        idle(10);
        msg_ready = 1; idle(2); msg_ready = 0;
        chk(msg_valid == 0, "R5 held level no repeat", msg_valid, 0);
        src[5] = 1'b0;

        // R3 masked source: pending only; request write ignored
        pulse_src(3);
        rd_exp(12'h008, 32'h08, "R3 masked source pending");
        chk(msg_valid == 0, "R3 masked source no message", msg_valid, 0);
        wr(12'h000, 32'hFFFF_FFFF);
        rd_exp(12'h000, 32'h20, "R3 request write ignored");
        pulse_src(3);
        wr(12'h008, 32'h1234);
        rd_exp(12'h008, 32'h0, "R4 pending cleared by write");

        // R6 control bit
        wr(12'h00C, 32'hFFFF_FFFF);
        rd_exp(12'h00C, 32'h100, "R6 control reads bit 8 only");
        pulse_src(7);
        chk(msg_valid == 0, "R6 bus error blocks message", msg_valid, 0);
        rd_exp(12'h000, 32'hA0, "R6 request still updates");
        wr(12'h00C, 32'h0);

        // R8 overflow with stalled port
        for (int i = 0; i < 6; i++) pulse_src(7);
        rd_exp(12'h104, 32'h8000_0000, "R8 overflow bit set");
        msg_ready = 1; idle(8); msg_ready = 0;
        chk(msg_valid == 0, "R7 FIFO drained", msg_valid, 0);
        rd_exp(12'h104, 32'h8000_0000, "R8 overflow bit sticky");

        // R11 plain storage
        wr(12'h104, 32'h0000_005A);
        rd_exp(12'h104, 32'h5A, "R11 error log rw");
        wr(12'h110, 32'hA5A5_0F0F);
        rd_exp(12'h110, 32'hA5A5_0F0F, "R11 arbitration mask rw");

        // R9 mask legality
        wr(12'h004, 32'h1);
        rd_exp(12'h004, 32'h1, "R9 illegal mask stored");
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h004, LEGAL);

        // R10 power control
        wr(12'h100, 32'h3);
        wr(12'h100, 32'h2);
        rd_exp(12'h100, 0, "R10 power reads zero");
        rd_exp(12'h108, 0, "R10 version reads zero");
        wr(12'h10C, 32'hFFFF_FFFF);
        rd_exp(12'h10C, 0, "R10 io reset reads zero");
        rd_exp(12'h200, 0, "R2 unmapped reads zero");

        // R5 simultaneous edges coalesce into one message
        @(negedge clk); src[8] = 1; src[9] = 1;
        idle(6);
        msg_ready = 1; idle(1); msg_ready = 0;
        chk(msg_valid == 0, "R5 simultaneous edges one message", msg_valid, 0);
        src[8] = 0; src[9] = 0;

        // R4 reads every cycle while a source toggles
        msg_ready = 1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            reg_rd = 1; reg_addr = 12'h008;
            src[13] = (k % 3) == 0;
        end
        @(negedge clk); reg_rd = 0; src[13] = 0;
        idle(8);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule